// File: doc/BRIEF.md
# Four-Channel DAC Calibration Register Bank

This block holds the per-channel settings of a four-channel, 16-bit digital-to-analog converter. An upstream serial receiver hands it complete 24-bit command words, each qualified by a one-cycle valid strobe. The bank checks each word against its device address strap, decodes which register it targets and updates the output code, gain trim, offset trim or clear code of one channel. Gain and offset may also be written to every channel with a single command. A separate clear input, which may arrive from outside the clock domain, forces the output code of each clear-enabled channel to that channel's stored clear code.

Commands pass through a three-state machine. ST_IDLE latches a word when the strobe is high and moves to ST_DECODE. From ST_DECODE the machine moves to ST_WRITE when the word is a write (top bit 0), its device field equals the strap and its select code is a defined one; any other word sends it back to ST_IDLE. ST_WRITE raises the write enables for one cycle and always returns to ST_IDLE. Strobes that arrive outside ST_IDLE are not taken. The output code, gain, offset and clear-enable state of every channel leave the block as flat buses; the gain and offset arithmetic and the analog stage are downstream of it.

Top module: `dac_cal_regbank`

## Requirements
- R1: A command word is laid out as bit 23 read flag, bits 22:21 device field, bits 20:18 select code, bits 17:16 channel, bits 15:0 payload; a word with bit 23 set changes no register.
- R2: A word whose device field differs from the `strap_addr` input changes no register.
- R3: Select code 000 writes the payload into the output code of the addressed channel only; channel n sits at bits 16n+15:16n of each output bus.
- R4: Select code 010 writes the payload into the gain of the addressed channel only; code 011 writes it into all four gains, whatever the channel field.
- R5: Select code 100 writes the payload into the offset of the addressed channel only; code 101 writes it into all four offsets, whatever the channel field.
- R6: Select code 110 writes the payload into the clear code of the addressed channel and sets the clear-enable vector from payload bits 3:0, bit n enabling channel n (`clear_en[n]`).
- R7: After reset every output code is 0x0000, every gain 0xFFFF, every offset 0x8000 (zero offset, straight binary), every clear code 0x0000 and every clear enable 0.
- R8: `clear_in` passes through a two-flop synchronizer; a rising edge loads each enabled channel's clear code into its output code, visible after the third rising clock edge that sees `clear_in` high; disabled channels keep their output code, and a level held high loads only once.
- R9: When a clear load and an output-code write reach an enabled channel in the same cycle, the clear code wins; a disabled channel takes the write.
- R10: Select codes 001 and 111 change no register.
- R11: A word strobed in ST_IDLE takes effect after the third rising edge counting the one that latched it; a strobe arriving while the machine is in ST_DECODE or ST_WRITE is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| strap_addr | input | 2 | Device address this bank answers to |
| cmd_word | input | 24 | Deserialized command word |
| cmd_valid | input | 1 | One-cycle strobe qualifying `cmd_word` |
| clear_in | input | 1 | Clear request, asynchronous, rising-edge active |
| dac_data | output | 64 | Output codes, channel n at bits 16n+15:16n |
| dac_gain | output | 64 | Gain trims, channel n at bits 16n+15:16n |
| dac_offset | output | 64 | Offset trims, channel n at bits 16n+15:16n |
| clear_en | output | 4 | Clear enable per channel |

## Verification
Single-channel writes go to distinct channels with distinct payloads so that a wrong channel decode shows as a value in the wrong slice, while broadcast gain and offset words carry a channel field that is not zero to separate a true broadcast from a single write. Rejected words (read flag set, wrong device field, each undefined select code, and a second strobe during decode) are followed by an unchanged bank, which tells apart filtering from mere latency. Clear is raised with a mix of enabled and disabled channels, held high across a later write, and raised in the very cycle a write lands on both an enabled and a disabled channel, which isolates the clear-versus-write priority. A behavioural model compares every output bus on every clock, so the three-edge latency of both commands and clears is pinned exactly.

// File: rtl/dcrb_pkg.sv
package dcrb_pkg;

    // Width of the register-select field; fixed by the code set below.
    localparam int unsigned SEL_W = 3;

    typedef enum logic [SEL_W-1:0] {
        SEL_DATA     = 3'b000,
        SEL_RSVD_A   = 3'b001,
        SEL_GAIN     = 3'b010,
        SEL_GAIN_ALL = 3'b011,
        SEL_OFFS     = 3'b100,
        SEL_OFFS_ALL = 3'b101,
        SEL_CLR      = 3'b110,
        SEL_RSVD_B   = 3'b111
    } reg_sel_e;

    typedef enum logic [1:0] {
        ST_IDLE   = 2'd0,
        ST_DECODE = 2'd1,
        ST_WRITE  = 2'd2
    } cmd_state_e;

endpackage

// File: rtl/dcrb_clr_sync.sv
module dcrb_clr_sync (
    input  logic clk,
    input  logic rst_n,
    input  logic clear_in,
    output logic clr_pulse
);

    logic meta_q;
    logic sync_q;
    logic prev_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            meta_q <= 1'b0;
            sync_q <= 1'b0;
            prev_q <= 1'b0;
        end else begin
            meta_q <= clear_in;
            sync_q <= meta_q;
            prev_q <= sync_q;
        end
    end

    assign clr_pulse = sync_q & ~prev_q;

    // R8
    clr_pulse_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        clr_pulse |=> !clr_pulse);

endmodule

// File: rtl/dcrb_cmd_fsm.sv
module dcrb_cmd_fsm
    import dcrb_pkg::*;
#(
    parameter int CH_N   = 4,
    parameter int DATA_W = 16,
    parameter int DEV_W  = 2,
    localparam int CH_W   = $clog2(CH_N),
    localparam int WORD_W = 1 + DEV_W + SEL_W + CH_W + DATA_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [DEV_W-1:0]  strap_addr,
    input  logic [WORD_W-1:0] cmd_word,
    input  logic              cmd_valid,
    output logic [CH_N-1:0]   we_data,
    output logic [CH_N-1:0]   we_gain,
    output logic [CH_N-1:0]   we_offs,
    output logic [CH_N-1:0]   we_clr,
    output logic              en_we,
    output logic [DATA_W-1:0] wr_payload
);

    localparam int CH_LSB  = DATA_W;
    localparam int SEL_LSB = CH_LSB + CH_W;
    localparam int DEV_LSB = SEL_LSB + SEL_W;
    localparam int RD_BIT  = DEV_LSB + DEV_W;

    cmd_state_e        state_q;
    cmd_state_e        state_d;
    logic [WORD_W-1:0] cmd_q;

    logic              rd_flag;
    logic [DEV_W-1:0]  dev_fld;
    reg_sel_e          sel_fld;
    logic [CH_W-1:0]   ch_fld;
    logic [CH_N-1:0]   ch_onehot;
    logic              sel_known;
    logic              cmd_ok;

    assign rd_flag    = cmd_q[RD_BIT];
    assign dev_fld    = cmd_q[DEV_LSB +: DEV_W];
    assign sel_fld    = reg_sel_e'(cmd_q[SEL_LSB +: SEL_W]);
    assign ch_fld     = cmd_q[CH_LSB +: CH_W];
    assign wr_payload = cmd_q[DATA_W-1:0];
    assign ch_onehot  = CH_N'(1) << ch_fld;

    always_comb begin
        unique case (sel_fld)
            SEL_DATA, SEL_GAIN, SEL_GAIN_ALL,
            SEL_OFFS, SEL_OFFS_ALL, SEL_CLR: sel_known = 1'b1;
            default:                          sel_known = 1'b0;
        endcase
    end

    assign cmd_ok = !rd_flag && (dev_fld == strap_addr) && sel_known;

    // State register and command latch.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            cmd_q   <= '0;
        end else begin
            state_q <= state_d;
            if (state_q == ST_IDLE && cmd_valid) begin
                cmd_q <= cmd_word;
            end
        end
    end

    // Transitions.
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:   if (cmd_valid) state_d = ST_DECODE;
            ST_DECODE: state_d = cmd_ok ? ST_WRITE : ST_IDLE;
            ST_WRITE:  state_d = ST_IDLE;
            default:   state_d = ST_IDLE;
        endcase
    end

    // Write enables, raised only in ST_WRITE.
    always_comb begin
        we_data = '0;
        we_gain = '0;
        we_offs = '0;
        we_clr  = '0;
        en_we   = 1'b0;
        if (state_q == ST_WRITE) begin
            unique case (sel_fld)
                SEL_DATA:     we_data = ch_onehot;
                SEL_GAIN:     we_gain = ch_onehot;
                SEL_GAIN_ALL: we_gain = '1;
                SEL_OFFS:     we_offs = ch_onehot;
                SEL_OFFS_ALL: we_offs = '1;
                SEL_CLR: begin
                    we_clr = ch_onehot;
                    en_we  = 1'b1;
                end
                default: ;
            endcase
        end
    end

    // R11
    write_follows_decode_chk: assert property (@(posedge clk) disable iff (!rst_n)
        state_q == ST_WRITE |-> $past(state_q) == ST_DECODE);

    // R11
    busy_word_held_chk: assert property (@(posedge clk) disable iff (!rst_n)
        state_q != ST_IDLE |=> $stable(cmd_q));

    // R2
    strap_mismatch_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_DECODE && dev_fld != strap_addr) |=> state_q == ST_IDLE);

    // R1
    read_word_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_DECODE && rd_flag) |=> state_q == ST_IDLE);

    // R10
    reserved_sel_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_DECODE && (sel_fld == SEL_RSVD_A || sel_fld == SEL_RSVD_B))
        |=> state_q == ST_IDLE);

endmodule

// File: rtl/dcrb_chan.sv
module dcrb_chan #(
    parameter int DATA_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              we_data,
    input  logic              we_gain,
    input  logic              we_offs,
    input  logic              we_clr,
    input  logic              en_we,
    input  logic              en_bit,
    input  logic [DATA_W-1:0] wr_payload,
    input  logic              clr_pulse,
    output logic [DATA_W-1:0] data_q,
    output logic [DATA_W-1:0] gain_q,
    output logic [DATA_W-1:0] offs_q,
    output logic              clr_en_q
);

    localparam logic [DATA_W-1:0] DATA_RST = '0;
    localparam logic [DATA_W-1:0] GAIN_RST = '1;
    localparam logic [DATA_W-1:0] OFFS_RST = DATA_W'(1) << (DATA_W - 1);
    localparam logic [DATA_W-1:0] CLR_RST  = '0;

    logic [DATA_W-1:0] clr_code_q;

    // Output code: a clear load outranks a write.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            data_q <= DATA_RST;
        end else if (clr_pulse && clr_en_q) begin
            data_q <= clr_code_q;
        end else if (we_data) begin
            data_q <= wr_payload;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            gain_q <= GAIN_RST;
        end else if (we_gain) begin
            gain_q <= wr_payload;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            offs_q <= OFFS_RST;
        end else if (we_offs) begin
            offs_q <= wr_payload;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            clr_code_q <= CLR_RST;
            clr_en_q   <= 1'b0;
        end else begin
            if (we_clr) begin
                clr_code_q <= wr_payload;
            end
            if (en_we) begin
                clr_en_q <= en_bit;
            end
        end
    end

    // R4
    gain_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !we_gain |=> $stable(gain_q));

    // R5
    offs_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !we_offs |=> $stable(offs_q));

    // R8
    clr_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_pulse && clr_en_q) |=> data_q == $past(clr_code_q));

    // R9
    clr_beats_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_pulse && clr_en_q && we_data && wr_payload != clr_code_q)
        |=> data_q != $past(wr_payload));

    // R3
    data_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!we_data && !(clr_pulse && clr_en_q)) |=> $stable(data_q));

endmodule

// File: rtl/dac_cal_regbank.sv
module dac_cal_regbank
    import dcrb_pkg::*;
#(
    parameter int CH_N   = 4,
    parameter int DATA_W = 16,
    parameter int DEV_W  = 2,
    localparam int CH_W   = $clog2(CH_N),
    localparam int WORD_W = 1 + DEV_W + SEL_W + CH_W + DATA_W,
    localparam int BUS_W  = CH_N * DATA_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [DEV_W-1:0]  strap_addr,
    input  logic [WORD_W-1:0] cmd_word,
    input  logic              cmd_valid,
    input  logic              clear_in,
    output logic [BUS_W-1:0]  dac_data,
    output logic [BUS_W-1:0]  dac_gain,
    output logic [BUS_W-1:0]  dac_offset,
    output logic [CH_N-1:0]   clear_en
);

    logic [CH_N-1:0]   we_data;
    logic [CH_N-1:0]   we_gain;
    logic [CH_N-1:0]   we_offs;
    logic [CH_N-1:0]   we_clr;
    logic              en_we;
    logic [DATA_W-1:0] wr_payload;
    logic              clr_pulse;

    dcrb_cmd_fsm #(
        .CH_N   (CH_N),
        .DATA_W (DATA_W),
        .DEV_W  (DEV_W)
    ) u_fsm (
        .clk        (clk),
        .rst_n      (rst_n),
        .strap_addr (strap_addr),
        .cmd_word   (cmd_word),
        .cmd_valid  (cmd_valid),
        .we_data    (we_data),
        .we_gain    (we_gain),
        .we_offs    (we_offs),
        .we_clr     (we_clr),
        .en_we      (en_we),
        .wr_payload (wr_payload)
    );

    dcrb_clr_sync u_clr_sync (
        .clk       (clk),
        .rst_n     (rst_n),
        .clear_in  (clear_in),
        .clr_pulse (clr_pulse)
    );

    for (genvar g = 0; g < CH_N; g++) begin : g_chan
        dcrb_chan #(
            .DATA_W (DATA_W)
        ) u_chan (
            .clk        (clk),
            .rst_n      (rst_n),
            .we_data    (we_data[g]),
            .we_gain    (we_gain[g]),
            .we_offs    (we_offs[g]),
            .we_clr     (we_clr[g]),
            .en_we      (en_we),
            .en_bit     (wr_payload[g]),
            .wr_payload (wr_payload),
            .clr_pulse  (clr_pulse),
            .data_q     (dac_data[g*DATA_W +: DATA_W]),
            .gain_q     (dac_gain[g*DATA_W +: DATA_W]),
            .offs_q     (dac_offset[g*DATA_W +: DATA_W]),
            .clr_en_q   (clear_en[g])
        );
    end

    // R6
    enable_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !en_we |=> $stable(clear_en));

    // R4
    gain_onehot_or_all_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(we_gain) || (we_gain == '1));

endmodule

// File: tb/dac_cal_regbank_bench.sv
module dac_cal_regbank_bench;

    localparam int CLK_PERIOD = 10;
    localparam int NCH = 4;
    localparam int DW  = 16;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [1:0]  strap_addr = 2'b10;
    logic [23:0] cmd_word = '0;
    logic        cmd_valid = 1'b0;
    logic        clear_in = 1'b0;
    logic [63:0] dac_data;
    logic [63:0] dac_gain;
    logic [63:0] dac_offset;
    logic [3:0]  clear_en;

    int    checks = 0;
    int    errors = 0;
    string cur_req = "R7";
    bit    done = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    dac_cal_regbank u_dac_cal_regbank (
        .clk        (clk),
        .rst_n      (rst_n),
        .strap_addr (strap_addr),
        .cmd_word   (cmd_word),
        .cmd_valid  (cmd_valid),
        .clear_in   (clear_in),
        .dac_data   (dac_data),
        .dac_gain   (dac_gain),
        .dac_offset (dac_offset),
        .clear_en   (clear_en)
    );

    // ---------------- behavioural reference ----------------
    int unsigned m_data [NCH];
    int unsigned m_gain [NCH];
    int unsigned m_offs [NCH];
    int unsigned m_clr  [NCH];
    bit          m_en   [NCH];
    bit          clr_hist[$];   // newest sample first
    int          phase = 0;     // 0 free, 1 word held, 2 word to apply
    logic [23:0] m_word;

    function automatic bit word_ok(logic [23:0] w, logic [1:0] strap);
        int s;
        s = int'(w[20:18]);
        return (w[23] == 1'b0) && (w[22:21] == strap) && (s != 1) && (s != 7);
    endfunction

    always @(posedge clk) begin
        int unsigned old_clr[NCH];
        bit          old_en[NCH];
        bit          pulse;
        int          s;
        int          c;
        if (!rst_n) begin
            for (int i = 0; i < NCH; i++) begin
                m_data[i] = 0; m_gain[i] = 32'hFFFF; m_offs[i] = 32'h8000;
                m_clr[i] = 0; m_en[i] = 1'b0;
            end
            clr_hist = '{1'b0, 1'b0, 1'b0};
            phase = 0;
        end else begin
            for (int i = 0; i < NCH; i++) begin
                old_clr[i] = m_clr[i];
                old_en[i]  = m_en[i];
            end
            pulse = clr_hist[1] && !clr_hist[2];
            clr_hist.push_front(clear_in);
            void'(clr_hist.pop_back());
            if (phase == 2) begin
                s = int'(m_word[20:18]);
                c = int'(m_word[17:16]);
                case (s)
                    0: m_data[c] = m_word[15:0];
                    2: m_gain[c] = m_word[15:0];
                    3: for (int i = 0; i < NCH; i++) m_gain[i] = m_word[15:0];
                    4: m_offs[c] = m_word[15:0];
                    5: for (int i = 0; i < NCH; i++) m_offs[i] = m_word[15:0];
                    6: begin
                        m_clr[c] = m_word[15:0];
                        for (int i = 0; i < NCH; i++) m_en[i] = m_word[i];
                    end
                    default: ;
                endcase
                phase = 0;
            end else if (phase == 1) begin
                phase = word_ok(m_word, strap_addr) ? 2 : 0;
            end else if (cmd_valid) begin
                m_word = cmd_word;
                phase = 1;
            end
            if (pulse) begin
                for (int i = 0; i < NCH; i++) if (old_en[i]) m_data[i] = old_clr[i];
            end
        end
    end

    // Per-cycle comparison, away from the active edge.
    always @(negedge clk) begin
        if (rst_n && !done) begin
            bit bad;
            bad = 1'b0;
            checks++;
            for (int i = 0; i < NCH; i++) begin
                if (!bad && dac_data[16*i +: 16] != m_data[i][15:0]) begin
                    bad = 1'b1;
                    $display("FAIL %s cycle model: data ch%0d actual=%h expected=%h",
                             cur_req, i, dac_data[16*i +: 16], m_data[i][15:0]);
                end
                if (!bad && dac_gain[16*i +: 16] != m_gain[i][15:0]) begin
                    bad = 1'b1;
                    $display("FAIL %s cycle model: gain ch%0d actual=%h expected=%h",
                             cur_req, i, dac_gain[16*i +: 16], m_gain[i][15:0]);
                end
                if (!bad && dac_offset[16*i +: 16] != m_offs[i][15:0]) begin
                    bad = 1'b1;
                    $display("FAIL %s cycle model: offset ch%0d actual=%h expected=%h",
                             cur_req, i, dac_offset[16*i +: 16], m_offs[i][15:0]);
                end
                if (!bad && clear_en[i] != m_en[i]) begin
                    bad = 1'b1;
                    $display("FAIL %s cycle model: clear_en ch%0d actual=%b expected=%b",
                             cur_req, i, clear_en[i], m_en[i]);
                end
            end
            if (bad) errors++;
        end
    end

    // ---------------- helpers ----------------
    function automatic logic [23:0] mk(bit rd, logic [1:0] dev, logic [2:0] sel,
                                       logic [1:0] ch, logic [15:0] d);
        return {rd, dev, sel, ch, d};
    endfunction

    task automatic chk(string req, string what, logic [63:0] act, logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    // Strobe one word; returns at the negedge after the latching edge.
    task automatic strobe(logic [23:0] w);
        cmd_word  = w;
        cmd_valid = 1'b1;
        @(negedge clk);
        cmd_valid = 1'b0;
    endtask

    // Strobe and wait until the effect is visible (third edge).
    task automatic send(logic [23:0] w);
        strobe(w);
        repeat (2) @(negedge clk);
    endtask

    task automatic finish_run();
        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL R11 watchdog actual=running expected=finished");
            finish_run();
        end
    end

    // ---------------- stimulus ----------------
    initial begin
        logic [63:0] snap_d, snap_g, snap_o;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R7 reset values
        cur_req = "R7";
        chk("R7", "reset data",   dac_data,   64'h0);
        chk("R7", "reset gain",   dac_gain,   64'hFFFF_FFFF_FFFF_FFFF);
        chk("R7", "reset offset", dac_offset, 64'h8000_8000_8000_8000);
        chk("R7", "reset clear_en", {60'h0, clear_en}, 64'h0);

        // R3 single data write, channel 1
        cur_req = "R3";
        send(mk(0, 2'b10, 3'b000, 2'd1, 16'h1234));
        chk("R3", "data write ch1", dac_data, 64'h0000_0000_1234_0000);

        // R11 latency: not visible after two edges, visible after three
        cur_req = "R11";
        strobe(mk(0, 2'b10, 3'b000, 2'd3, 16'h0CCC));
        @(negedge clk);
        chk("R11", "data before third edge", dac_data, 64'h0000_0000_1234_0000);
        @(negedge clk);
        chk("R11", "data after third edge", dac_data, 64'h0CCC_0000_1234_0000);

        // R4 gain single and broadcast
        cur_req = "R4";
        send(mk(0, 2'b10, 3'b010, 2'd2, 16'h7FFF));
        chk("R4", "gain ch2", dac_gain, 64'hFFFF_7FFF_FFFF_FFFF);
        send(mk(0, 2'b10, 3'b011, 2'd1, 16'hABCD));
        chk("R4", "gain broadcast", dac_gain, 64'hABCD_ABCD_ABCD_ABCD);

        // R5 offset single and broadcast
        cur_req = "R5";
        send(mk(0, 2'b10, 3'b100, 2'd3, 16'h0001));
        chk("R5", "offset ch3", dac_offset, 64'h0001_8000_8000_8000);
        send(mk(0, 2'b10, 3'b101, 2'd2, 16'h9000));
        chk("R5", "offset broadcast", dac_offset, 64'h9000_9000_9000_9000);

        // R6 clear codes and enables (low nibble 0101 -> ch0, ch2)
        cur_req = "R6";
        send(mk(0, 2'b10, 3'b110, 2'd0, 16'h5555));
        send(mk(0, 2'b10, 3'b110, 2'd2, 16'h2225));
        chk("R6", "clear_en", {60'h0, clear_en}, 64'h5);

        cur_req = "R3";
        send(mk(0, 2'b10, 3'b000, 2'd0, 16'h0AAA));
        send(mk(0, 2'b10, 3'b000, 2'd2, 16'h0BBB));
        chk("R3", "data ch0 ch2", dac_data, 64'h0CCC_0BBB_1234_0AAA);

        // R8 clear: two edges not yet, third edge loads enabled channels
        cur_req = "R8";
        clear_in = 1'b1;
        repeat (2) @(negedge clk);
        chk("R8", "data before clear lands", dac_data, 64'h0CCC_0BBB_1234_0AAA);
        @(negedge clk);
        chk("R8", "data after clear", dac_data, 64'h0CCC_2225_1234_5555);
        // held high: a later write lands normally
        send(mk(0, 2'b10, 3'b000, 2'd0, 16'h0111));
        chk("R8", "write while clear held", dac_data, 64'h0CCC_2225_1234_0111);
        clear_in = 1'b0;
        repeat (3) @(negedge clk);

        // R9 same-cycle clear and write: enabled ch2 takes clear code
        cur_req = "R9";
        clear_in = 1'b1;
        send(mk(0, 2'b10, 3'b000, 2'd2, 16'h4444));
        chk("R9", "clear beats write ch2", dac_data, 64'h0CCC_2225_1234_5555);
        clear_in = 1'b0;
        repeat (3) @(negedge clk);
        // disabled ch1 takes the write in the same situation
        clear_in = 1'b1;
        send(mk(0, 2'b10, 3'b000, 2'd1, 16'h4321));
        chk("R9", "disabled ch1 takes write", dac_data, 64'h0CCC_2225_4321_5555);
        clear_in = 1'b0;
        repeat (3) @(negedge clk);

        snap_d = dac_data; snap_g = dac_gain; snap_o = dac_offset;

        // R1 read flag set
        cur_req = "R1";
        send(mk(1, 2'b10, 3'b000, 2'd3, 16'hDEAD));
        send(mk(1, 2'b10, 3'b011, 2'd0, 16'hDEAD));
        chk("R1", "data after read word", dac_data, snap_d);
        chk("R1", "gain after read word", dac_gain, snap_g);

        // R2 wrong device field, then a changed strap that matches
        cur_req = "R2";
        send(mk(0, 2'b01, 3'b000, 2'd3, 16'hBEEF));
        chk("R2", "data after foreign word", dac_data, snap_d);
        strap_addr = 2'b01;
        send(mk(0, 2'b01, 3'b000, 2'd3, 16'hBEEF));
        chk("R2", "data after matching strap", dac_data, {16'hBEEF, snap_d[47:0]});
        strap_addr = 2'b10;
        snap_d = dac_data;

        // R10 reserved select codes
        cur_req = "R10";
        send(mk(0, 2'b10, 3'b001, 2'd0, 16'h0F0F));
        send(mk(0, 2'b10, 3'b111, 2'd1, 16'h0F0F));
        chk("R10", "data after reserved", dac_data, snap_d);
        chk("R10", "gain after reserved", dac_gain, snap_g);
        chk("R10", "offset after reserved", dac_offset, snap_o);
        chk("R10", "clear_en after reserved", {60'h0, clear_en}, 64'h5);

        // R11 strobe during decode is ignored
        cur_req = "R11";
        strobe(mk(0, 2'b10, 3'b000, 2'd3, 16'h1111));
        strobe(mk(0, 2'b10, 3'b000, 2'd3, 16'h2222));
        repeat (3) @(negedge clk);
        chk("R11", "busy strobe ignored", dac_data, {16'h1111, snap_d[47:0]});

        repeat (2) @(negedge clk);
        finish_run();
    end

endmodule